// File: doc/BRIEF.md
# Three-Stage Timebase Watchdog

This block watches a free-running timebase counter and escalates through three stages each time a chosen bit of that counter goes from 0 to 1. The first such event only arms the watchdog. The second event flags an interrupt condition. The third event requests a reset. Software keeps the watchdog quiet by clearing the two status bits before the next event arrives.

The timebase advances by one on every clock where its enable input is high. A control register selects the watched bit through a 6-bit period value, which is split across two fields. The same register enables the interrupt output and holds a reset-kind field. Once that field is nonzero, it can no longer be changed.

All registers sit behind a small port with one write strobe, an address and a combinational read. The timebase can be read as two 32-bit halves. The outputs are a level interrupt, a one-cycle reset request and the reset kind that goes with it.

Top module: `wdog_escalator`

## Requirements
- R1: After reset, every register reads zero, `irq` is 0 and `rst_req` is 0.
- R2: The control word at address 0 holds a 6-bit period p. Bits 31:30 carry p[1:0] and bits 20:17 carry p[5:2]. The watched bit is timebase bit 63-p, so an event happens every 2^(64-p) enabled ticks, one cycle after that bit rises.
- R3: An event with the arm bit (status bit 31) clear sets the arm bit and signals nothing else.
- R4: An event with the arm bit set and the flag bit (status bit 30) clear sets the flag bit. `irq` equals the flag bit ANDed with interrupt-enable (control bit 26).
- R5: An event with both status bits set and a nonzero reset-kind field (control bits 29:28) produces these results:
  - `rst_req` is high for exactly one cycle.
  - `rst_kind` carries the field value during that cycle.
  - Both status bits read 0 afterwards.
- R6: If the reset-kind field is 0, an event with both status bits set requests no reset and leaves both bits set.
- R7: Writing to the status register at address 1 follows these rules:
  - A 1 in bit 31 or bit 30 clears that bit.
  - A 0 in either position leaves that bit unchanged.
- R8: Once the reset-kind field is nonzero, control writes leave it unchanged. The other control fields still update.
- R9: A status clear and an event can fall in the same cycle. In that case the clear is applied first, and the event then acts on the cleared bits.
- R10: The timebase advances only when `tb_en` is high. It reads at address 2 (bits 31:0) and address 3 (bits 63:32).
- R11: A period of 0 watches bit 63, which is the longest interval. Over a short run with period 0, the status bits do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tb_en | input | 1 | Timebase count enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 control, 1 status, 2/3 timebase halves) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | Watchdog interrupt request |
| rst_req | output | 1 | One-cycle reset request |
| rst_kind | output | 2 | Reset-kind code, valid while `rst_req` is high |

## Verification
The interesting coincidence is a software ping landing in the same cycle as a timeout event while both status bits are set. The bench runs the timebase so that the watched bit rises, and it places a write-one-to-clear of both status bits on exactly the clock edge that consumes the event. It then judges the outcome in two ways. No reset pulse may appear in the following cycle, and the status must read back as armed-only. A design that processes the event before the clear would instead issue a reset or leave the flag set.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned RC_W   = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_TBLO = 2'd2;
  localparam logic [ADDR_W-1:0] A_TBHI = 2'd3;

  // control word field positions
  localparam int PLO_MSB = 31;
  localparam int PLO_LSB = 30;
  localparam int RC_MSB  = 29;
  localparam int RC_LSB  = 28;
  localparam int IE_BIT  = 26;
  localparam int PHI_MSB = 20;
  localparam int PHI_LSB = 17;

  // status word field positions
  localparam int ARM_BIT  = 31;
  localparam int FLAG_BIT = 30;
endpackage

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
  parameter int unsigned TB_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  output logic [TB_W-1:0] tb_o
);
  logic [TB_W-1:0] tb_q, tb_d;

  always_comb begin
    tb_d = tb_q;
    if (en_i) tb_d = tb_q + TB_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tb_q <= '0;
    else        tb_q <= tb_d;
  end

  assign tb_o = tb_q;

  // R10
  tb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(tb_q));
endmodule

// File: rtl/wdt_event_det.sv
module wdt_event_det #(
  parameter int unsigned TB_W = 64,
  localparam int unsigned PER_W = $clog2(TB_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TB_W-1:0]  tb_i,
  input  logic [PER_W-1:0] period_i,
  output logic             evt_o
);
  logic [PER_W-1:0] idx;
  logic             sel, prev_q;

  always_comb begin
    idx = PER_W'(TB_W - 1) - period_i;
    sel = tb_i[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sel;
  end

  assign evt_o = sel & ~prev_q;

  // R2
  evt_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> !evt_o || $changed(period_i));
endmodule

// File: rtl/wdt_stage_ctl.sv
module wdt_stage_ctl #(
  parameter int unsigned RC_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            evt_i,
  input  logic            ie_i,
  input  logic [RC_W-1:0] rc_i,
  input  logic            clr_arm_i,
  input  logic            clr_flag_i,
  output logic            arm_o,
  output logic            flag_o,
  output logic            irq_o,
  output logic            req_o,
  output logic [RC_W-1:0] kind_o
);
  logic            arm_q, arm_d, flag_q, flag_d, arm_m, flag_m;
  logic            req_q, req_d;
  logic [RC_W-1:0] kind_q, kind_d;

  always_comb begin
    arm_m  = arm_q  & ~clr_arm_i;
    flag_m = flag_q & ~clr_flag_i;
    arm_d  = arm_m;
    flag_d = flag_m;
    req_d  = 1'b0;
    kind_d = '0;
    if (evt_i) begin
      if (!arm_m) begin
        arm_d = 1'b1;
      end else if (!flag_m) begin
        flag_d = 1'b1;
      end else if (rc_i != '0) begin
        req_d  = 1'b1;
        kind_d = rc_i;
        arm_d  = 1'b0;
        flag_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      flag_q <= 1'b0;
      req_q  <= 1'b0;
      kind_q <= '0;
    end else begin
      arm_q  <= arm_d;
      flag_q <= flag_d;
      req_q  <= req_d;
      kind_q <= kind_d;
    end
  end

  assign arm_o  = arm_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & ie_i;
  assign req_o  = req_q;
  assign kind_o = kind_q;

  // R5
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q);
  // R5
  req_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (!arm_q && !flag_q && kind_q != '0));
  // R3
  arm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arm_q) |-> $past(evt_i));
  // R6
  no_kind_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && rc_i == '0 && arm_q && flag_q && !clr_arm_i && !clr_flag_i)
      |=> (arm_q && flag_q && !req_q));
endmodule

// File: rtl/wdog_escalator.sv
module wdog_escalator
  import wdt_pkg::*;
#(
  parameter int unsigned TB_W = 64,
  localparam int unsigned PER_W = $clog2(TB_W),
  localparam int unsigned TBX_W = 2 * REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tb_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              irq,
  output logic              rst_req,
  output logic [RC_W-1:0]   rst_kind
);
  logic [TB_W-1:0]  tb;
  logic [TBX_W-1:0] tb_x;
  logic [PER_W-1:0] per_q, per_d;
  logic             ie_q, ie_d;
  logic [RC_W-1:0]  rc_q, rc_d;
  logic             wr_ctrl, wr_stat, clr_arm, clr_flag;
  logic             evt, arm, flag;

  assign wr_ctrl  = wr_en && (addr == A_CTRL);
  assign wr_stat  = wr_en && (addr == A_STAT);
  assign clr_arm  = wr_stat && wdata[ARM_BIT];
  assign clr_flag = wr_stat && wdata[FLAG_BIT];

  always_comb begin
    per_d = per_q;
    ie_d  = ie_q;
    rc_d  = rc_q;
    if (wr_ctrl) begin
      per_d = PER_W'({wdata[PHI_MSB:PHI_LSB], wdata[PLO_MSB:PLO_LSB]});
      ie_d  = wdata[IE_BIT];
      if (rc_q == '0) rc_d = wdata[RC_MSB:RC_LSB];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      ie_q  <= 1'b0;
      rc_q  <= '0;
    end else begin
      per_q <= per_d;
      ie_q  <= ie_d;
      rc_q  <= rc_d;
    end
  end

  wdt_timebase #(.TB_W(TB_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .en_i(tb_en), .tb_o(tb)
  );

  wdt_event_det #(.TB_W(TB_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .tb_i(tb), .period_i(per_q), .evt_o(evt)
  );

  wdt_stage_ctl #(.RC_W(RC_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .ie_i(ie_q), .rc_i(rc_q),
    .clr_arm_i(clr_arm), .clr_flag_i(clr_flag),
    .arm_o(arm), .flag_o(flag), .irq_o(irq),
    .req_o(rst_req), .kind_o(rst_kind)
  );

  assign tb_x = TBX_W'(tb);

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[PLO_MSB:PLO_LSB] = per_q[1:0];
        rdata[PHI_MSB:PHI_LSB] = per_q[5:2];
        rdata[RC_MSB:RC_LSB]   = rc_q;
        rdata[IE_BIT]          = ie_q;
      end
      A_STAT: begin
        rdata[ARM_BIT]  = arm;
        rdata[FLAG_BIT] = flag;
      end
      A_TBLO:  rdata = tb_x[REG_W-1:0];
      default: rdata = tb_x[TBX_W-1:REG_W];
    endcase
  end

  // R8
  rc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rc_q != '0) |=> $stable(rc_q));
  // R4
  irq_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie_q);
endmodule

// File: tb/wdog_escalator_test.sv
module wdog_escalator_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tb_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, rst_req;
  logic [1:0]  rst_kind;

  int checks = 0;
  int fails = 0;
  int ticks = 0;
  int pulses;
  logic [1:0] last_kind;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_escalator uut (
    .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req),
    .rst_kind(rst_kind)
  );

  typedef struct packed {
    logic [1:0]  a;
    logic [31:0] d;
    logic [7:0]  run;
    logic [1:0]  st;
    logic        irq;
    logic [3:0]  nrst;
  } vec_t;

  // period 62 -> bit 1, one event per 4 ticks
  localparam vec_t VECS [11] = '{
    '{2'd0, 32'h801E_0000, 8'd0,  2'b00, 1'b0, 4'd0},
    '{2'd1, 32'h0000_0000, 8'd4,  2'b10, 1'b0, 4'd0},
    '{2'd1, 32'h0000_0000, 8'd4,  2'b11, 1'b0, 4'd0},
    '{2'd1, 32'h0000_0000, 8'd4,  2'b11, 1'b0, 4'd0},
    '{2'd1, 32'hC000_0000, 8'd0,  2'b00, 1'b0, 4'd0},
    '{2'd0, 32'h841E_0000, 8'd8,  2'b11, 1'b1, 4'd0},
    '{2'd1, 32'h4000_0000, 8'd0,  2'b10, 1'b0, 4'd0},
    '{2'd1, 32'h8000_0000, 8'd0,  2'b00, 1'b0, 4'd0},
    '{2'd0, 32'h941E_0000, 8'd12, 2'b00, 1'b0, 4'd1},
    '{2'd0, 32'h841E_0000, 8'd12, 2'b00, 1'b0, 4'd1},
    '{2'd0, 32'h801E_0000, 8'd8,  2'b11, 1'b0, 4'd0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic run(input int n);
    tb_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      if (rst_req) begin pulses++; last_kind = rst_kind; end
    end
    tb_en = 1'b0;
    ticks += n;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, r); check("R1 ctrl", r, 32'h0);
    rd(2'd1, r); check("R1 status", r, 32'h0);
    rd(2'd2, r); check("R1 tb", r, 32'h0);
    check("R1 irq/rst", {30'd0, irq, rst_req}, 32'h0);

    // R2 R3 R4 R5 R6 R7 R8 vector walk
    for (int v = 0; v < 11; v++) begin
      wr(VECS[v].a, VECS[v].d);
      pulses = 0;
      run(int'(VECS[v].run));
      rd(2'd1, r);
      check($sformatf("R2-vec%0d status", v), {30'd0, r[31:30]}, {30'd0, VECS[v].st});
      check($sformatf("R4-vec%0d irq", v), {31'd0, irq}, {31'd0, VECS[v].irq});
      check($sformatf("R5-vec%0d pulses", v), pulses, {28'd0, VECS[v].nrst});
    end
    // R8 reset-kind kept at 1
    rd(2'd0, r); check("R8 ctrl readback", r, 32'h901E_0000);

    // R9 clear and event on the same edge, state 11, reset kind 1
    wr(2'd0, 32'h841E_0000);
    check("R4 irq on", {31'd0, irq}, 32'h1);
    tb_en = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    addr = 2'd1; wdata = 32'hC000_0000; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    check("R9 no pulse", {31'd0, rst_req}, 32'h0);
    @(posedge clk); @(negedge clk);
    tb_en = 1'b0; ticks += 4;
    rd(2'd1, r); check("R9 status", r, 32'h8000_0000);

    // R4 then R5 kind
    pulses = 0; last_kind = 2'd0;
    run(4);
    check("R4 irq", {31'd0, irq}, 32'h1);
    run(4);
    check("R5 pulses", pulses, 1);
    check("R5 kind", {30'd0, last_kind}, 32'h1);
    rd(2'd1, r); check("R5 status", r, 32'h0);

    // R11 period 0
    wr(2'd0, 32'h0400_0000);
    rd(2'd0, r); check("R11 ctrl", r, 32'h1400_0000);
    pulses = 0;
    run(64);
    rd(2'd1, r); check("R11 status", r, 32'h0);
    check("R11 pulses", pulses, 0);

    // R10 timebase
    repeat (10) @(negedge clk);
    rd(2'd2, r); check("R10 tb lo", r, ticks);
    rd(2'd3, r); check("R10 tb hi", r, 32'h0);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule